// File: doc/BRIEF.md
# Floating-Point Min/Max/Sign Unit

A combinational unit for IEEE-754 words that returns the minimum or the maximum of two operands. It also provides absolute value, negation and an unmodified pass-through of the first operand. A format input chooses binary16 (half) or binary32 (single) for each operation. An opcode chooses the function. No status flags, exceptions or rounding are produced, because none of these functions rounds.

The two operands are ordered numerically. When either operand of min or max is a NaN, the result is a single canonical quiet NaN; the unit never returns the numeric operand in that case. Absolute value and negation change only the sign bit, so NaN payloads and infinities pass through with every other bit intact. A caller that wants one lane of a wider vector datapath instantiates one unit per element.

Top module: `fmm_unit`

## Requirements
- R1: `fmt_i`=0 selects half. In half mode only `a_i[15:0]` and `b_i[15:0]` are used, the result is placed on `y_o[15:0]`, and `y_o[31:16]` is zero. `fmt_i`=1 selects single, which uses all 32 bits.
- R2: The opcode encoding is 0 min, 1 max, 2 abs, 3 neg and 4 copy. Codes 5, 6 and 7 drive `y_o` to zero.
- R3: With no NaN present, min returns whichever operand has the smaller numeric value, with infinities at the extremes. When the two operands are equal, it returns `a`.
- R4: With no NaN present, max returns whichever operand has the larger numeric value. When the two operands are equal, it returns `a`.
- R5: If either operand of min or max is a NaN (exponent all ones, fraction non-zero, of either sign, quiet or signalling), the result is 0x7E00 in half mode and 0x7FC00000 in single mode.
- R6: A negative zero ranks below a positive zero. min(+0,−0) is −0 and max(+0,−0) is +0, in either operand order.
- R7: Negate inverts the sign bit of `a` (bit 15 in half mode, bit 31 in single mode) and leaves every other bit unchanged, including for NaN and infinity.
- R8: Absolute value clears the sign bit of `a` and leaves the exponent and the fraction (including a NaN payload) unchanged.
- R9: Copy returns the selected-width word of `a` bit-exactly.
- R10: For abs, neg and copy, `b_i` has no effect on `y_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fmt_i | input | 1 | 0 = half, 1 = single |
| op_i | input | 3 | Function select (see R2) |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| y_o | output | 32 | Result, zero-extended in half mode |

## Verification
The NaN override and the numeric ordering both act on the same min/max operation. The bench provokes them together by pairing a NaN with an infinity or a signed zero, where a broken override would let the ordering return the numeric operand. The expected result is the canonical NaN of the selected width, computed by a behavioural sign-and-magnitude model in the bench. Format selection also interacts with every function: single-precision patterns are driven with half selected, and the bench checks both that the upper bits are cleared and that a 16-bit NaN is recognised.

// File: rtl/fmm_pkg.sv
package fmm_pkg;
  typedef enum logic [2:0] {
    OP_MIN  = 3'd0,
    OP_MAX  = 3'd1,
    OP_ABS  = 3'd2,
    OP_NEG  = 3'd3,
    OP_COPY = 3'd4
  } fmm_op_e;
endpackage

// File: rtl/fmm_key.sv
// Maps a sign-magnitude float to an unsigned key whose integer order is the
// numeric order, and flags NaN encodings.
module fmm_key #(
  parameter int EXP_W = 5,
  parameter int MAN_W = 10,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] val_i,
  output logic [W-1:0] key_o,
  output logic         nan_o
);
  always_comb begin
    nan_o = (&val_i[W-2:MAN_W]) && (|val_i[MAN_W-1:0]);
    if (val_i[W-1]) key_o = ~val_i;
    else            key_o = {1'b1, val_i[W-2:0]};
  end
endmodule

// File: rtl/fmm_lane.sv
// One precision slice: all functions for a single format width.
module fmm_lane #(
  parameter int EXP_W = 5,
  parameter int MAN_W = 10,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  fmm_pkg::fmm_op_e op_i,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  output logic [W-1:0]     y_o
);
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic [W-1:0] key_a, key_b;
  logic         nan_a, nan_b;
  logic         a_below_b, b_below_a, any_nan;

  fmm_key #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_key_a (.val_i(a_i), .key_o(key_a), .nan_o(nan_a));
  fmm_key #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_key_b (.val_i(b_i), .key_o(key_b), .nan_o(nan_b));

  always_comb begin
    a_below_b = key_a < key_b;
    b_below_a = key_b < key_a;
    any_nan   = nan_a | nan_b;
    case (op_i)
      fmm_pkg::OP_MIN:  y_o = any_nan ? QNAN : (b_below_a ? b_i : a_i);
      fmm_pkg::OP_MAX:  y_o = any_nan ? QNAN : (a_below_b ? b_i : a_i);
      fmm_pkg::OP_ABS:  y_o = {1'b0, a_i[W-2:0]};
      fmm_pkg::OP_NEG:  y_o = {~a_i[W-1], a_i[W-2:0]};
      fmm_pkg::OP_COPY: y_o = a_i;
      default:          y_o = '0;
    endcase
  end
endmodule

// File: rtl/fmm_unit.sv
module fmm_unit #(
  parameter int H_EXP = 5,
  parameter int H_MAN = 10,
  parameter int S_EXP = 8,
  parameter int S_MAN = 23,
  localparam int H_W = 1 + H_EXP + H_MAN,
  localparam int S_W = 1 + S_EXP + S_MAN
) (
  input  logic           fmt_i,
  input  logic [2:0]     op_i,
  input  logic [S_W-1:0] a_i,
  input  logic [S_W-1:0] b_i,
  output logic [S_W-1:0] y_o
);
  fmm_pkg::fmm_op_e op;
  logic [H_W-1:0]   h_y;
  logic [S_W-1:0]   s_y;

  assign op = fmm_pkg::fmm_op_e'(op_i);

  fmm_lane #(.EXP_W(H_EXP), .MAN_W(H_MAN)) u_half (
    .op_i(op), .a_i(a_i[H_W-1:0]), .b_i(b_i[H_W-1:0]), .y_o(h_y));
  fmm_lane #(.EXP_W(S_EXP), .MAN_W(S_MAN)) u_single (
    .op_i(op), .a_i(a_i), .b_i(b_i), .y_o(s_y));

  always_comb begin
    if (fmt_i) y_o = s_y;
    else       y_o = {{(S_W-H_W){1'b0}}, h_y};
  end
endmodule

// File: rtl/fmm_unit_chk.sv
module fmm_unit_chk #(
  parameter int H_EXP = 5,
  parameter int H_MAN = 10,
  parameter int S_EXP = 8,
  parameter int S_MAN = 23,
  localparam int H_W = 1 + H_EXP + H_MAN,
  localparam int S_W = 1 + S_EXP + S_MAN
) (
  input logic           fmt_i,
  input logic [2:0]     op_i,
  input logic [S_W-1:0] a_i,
  input logic [S_W-1:0] b_i,
  input logic [S_W-1:0] y_o
);
  logic [S_W-1:0] sgn, wmask, canon;
  logic           na, nb;

  always_comb begin
    sgn   = fmt_i ? (S_W'(1) << (S_W-1)) : (S_W'(1) << (H_W-1));
    wmask = fmt_i ? '1 : {{(S_W-H_W){1'b0}}, {H_W{1'b1}}};
    canon = fmt_i ? {1'b0, {S_EXP{1'b1}}, 1'b1, {(S_MAN-1){1'b0}}}
                  : S_W'({1'b0, {H_EXP{1'b1}}, 1'b1, {(H_MAN-1){1'b0}}});
    if (fmt_i) begin
      na = (a_i[S_W-2:S_MAN] == '1) && (a_i[S_MAN-1:0] != '0);
      nb = (b_i[S_W-2:S_MAN] == '1) && (b_i[S_MAN-1:0] != '0);
    end else begin
      na = (a_i[H_W-2:H_MAN] == '1) && (a_i[H_MAN-1:0] != '0);
      nb = (b_i[H_W-2:H_MAN] == '1) && (b_i[H_MAN-1:0] != '0);
    end
  end

  always_comb begin
    if (!$isunknown({fmt_i, op_i, a_i, b_i, y_o})) begin
      p_half_upper_r1: assert (fmt_i || y_o[S_W-1:H_W] == '0);
      p_spare_ops_r2:  assert (op_i < 3'd5 || y_o == '0);
      if (op_i <= 3'd1 && !na && !nb)
        p_pick_operand_r3: assert (y_o == (a_i & wmask) || y_o == (b_i & wmask));
      if (op_i <= 3'd1 && (na || nb))
        p_nan_canon_r5: assert (y_o == canon);
      if (op_i == 3'd2)
        p_abs_sign_r8: assert (y_o == (a_i & wmask & ~sgn));
      if (op_i == 3'd3)
        p_neg_sign_r7: assert ((y_o ^ (a_i & wmask)) == sgn);
      if (op_i == 3'd4)
        p_copy_exact_r9: assert (y_o == (a_i & wmask));
    end
  end
endmodule

bind fmm_unit fmm_unit_chk #(.H_EXP(H_EXP), .H_MAN(H_MAN), .S_EXP(S_EXP), .S_MAN(S_MAN))
  u_fmm_unit_chk (.fmt_i(fmt_i), .op_i(op_i), .a_i(a_i), .b_i(b_i), .y_o(y_o));

// File: tb/test_fmm_unit.sv
module test_fmm_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fmt;
  logic [2:0]  op;
  logic [31:0] a, b, y;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fmm_unit i_fmm_unit (.fmt_i(fmt), .op_i(op), .a_i(a), .b_i(b), .y_o(y));

  function automatic bit is_nan(bit f, logic [31:0] v);
    if (f) return (v[30:23] == 8'hFF) && (v[22:0] != 0);
    return (v[14:10] == 5'h1F) && (v[9:0] != 0);
  endfunction

  // true when x is numerically below v (signed zeros: -0 below +0)
  function automatic bit less(bit f, logic [31:0] x, logic [31:0] v);
    int unsigned mx, mv;
    bit sx, sv;
    sx = f ? x[31] : x[15];
    sv = f ? v[31] : v[15];
    mx = f ? int'(x[30:0]) : int'(x[14:0]);
    mv = f ? int'(v[30:0]) : int'(v[14:0]);
    if (sx != sv) return sx;
    if (!sx) return mx < mv;
    return mx > mv;
  endfunction

  function automatic logic [31:0] model(bit f, logic [2:0] o, logic [31:0] x, logic [31:0] v);
    logic [31:0] xs, vs, s;
    xs = f ? x : {16'h0, x[15:0]};
    vs = f ? v : {16'h0, v[15:0]};
    s  = f ? 32'h8000_0000 : 32'h0000_8000;
    case (o)
      3'd0, 3'd1: begin
        if (is_nan(f, xs) || is_nan(f, vs)) return f ? 32'h7FC0_0000 : 32'h0000_7E00;
        if (o == 3'd0) return less(f, vs, xs) ? vs : xs;
        return less(f, xs, vs) ? vs : xs;
      end
      3'd2: return xs & ~s;
      3'd3: return xs ^ s;
      3'd4: return xs;
      default: return 32'h0;
    endcase
  endfunction

  task automatic run(bit f, logic [2:0] o, logic [31:0] x, logic [31:0] v, string req);
    logic [31:0] exp_y;
    @(posedge clk);
    fmt = f; op = o; a = x; b = v;
    exp_y = model(f, o, x, v);
    @(negedge clk);
    checks++;
    if (y !== exp_y) begin
      fails++;
      $display("FAIL %s fmt=%0d op=%0d a=%h b=%h actual=%h expected=%h",
               req, f, o, x, v, y, exp_y);
    end
  endtask

  initial begin
    fmt = 1'b0; op = 3'd0; a = '0; b = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;  // R1 R3: initial vector min(+0,+0) half is zero
    if (y !== 32'h0) begin fails++; $display("FAIL R1 actual=%h expected=0", y); end
    // R3 / R4 ordering, half
    run(0, 3'd0, 32'h3C00, 32'h4000, "R3");
    run(0, 3'd0, 32'h4000, 32'hBC00, "R3");
    run(0, 3'd1, 32'hBC00, 32'hC000, "R4");
    run(0, 3'd1, 32'hFC00, 32'h7C00, "R4");
    run(0, 3'd0, 32'h3C00, 32'h3C00, "R3");
    // R3 / R4 single
    run(1, 3'd0, 32'h3F80_0000, 32'h3F00_0000, "R3");
    run(1, 3'd1, 32'hC000_0000, 32'h3F00_0000, "R4");
    run(1, 3'd0, 32'hFF80_0000, 32'hC000_0000, "R3");
    run(1, 3'd1, 32'h7F80_0000, 32'h7F7F_FFFF, "R4");
    // R5 NaN override, combined with ordering extremes
    run(0, 3'd0, 32'h7C01, 32'hFC00, "R5");
    run(0, 3'd1, 32'h7C00, 32'hFE00, "R5");
    run(1, 3'd0, 32'h0000_0000, 32'hFF80_0001, "R5");
    run(1, 3'd1, 32'h7FC0_1234, 32'h7F80_0000, "R5");
    // R6 signed zeros, both orders
    run(0, 3'd0, 32'h0000, 32'h8000, "R6");
    run(0, 3'd0, 32'h8000, 32'h0000, "R6");
    run(1, 3'd1, 32'h8000_0000, 32'h0000_0000, "R6");
    run(1, 3'd1, 32'h0000_0000, 32'h8000_0000, "R6");
    // R7 negate
    run(0, 3'd3, 32'h7D55, 32'h1234, "R7");
    run(1, 3'd3, 32'hFF80_0000, 32'h0, "R7");
    // R8 abs
    run(0, 3'd2, 32'hFE01, 32'h0, "R8");
    run(1, 3'd2, 32'hFFC0_00AB, 32'h5, "R8");
    // R9 copy
    run(1, 3'd4, 32'hDEAD_BEEF, 32'h0, "R9");
    // R1 half mode with upper garbage
    run(0, 3'd4, 32'hDEAD_BEEF, 32'h0, "R1");
    run(0, 3'd0, 32'hFFFF_7C01, 32'h0000_3C00, "R1");
    // R10 b has no effect
    run(1, 3'd3, 32'h3F80_0000, 32'h7FC0_0000, "R10");
    run(1, 3'd3, 32'h3F80_0000, 32'hFFFF_FFFF, "R10");
    run(0, 3'd2, 32'hBC00, 32'h7E00, "R10");
    run(0, 3'd4, 32'hBC00, 32'hFFFF, "R10");
    // R2 spare opcodes
    run(1, 3'd5, 32'h3F80_0000, 32'h1, "R2");
    run(0, 3'd7, 32'hBC00, 32'h1, "R2");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule